// File: doc/BRIEF.md
# Synchronizable Clock Divider Bank

The block derives a set of output clocks from one high-speed distribution clock. Each channel has its own divide ratio, a digital delay counted in distribution-clock cycles, and a half-step bit that moves the output back by half a distribution period. A divide value of 0 or 1 passes the distribution clock straight through. For larger values the output has close to 50% duty, and an odd divide puts its extra cycle in the low phase.

A re-alignment request comes from an asynchronous pin or from a polarity-invert control bit. Any edge of the synchronised, polarity-corrected level fires a one-cycle pulse, so the toggle needs no precise timing. The request waits for the next falling edge of a selected running output, the qualifying channel. At that edge every channel without its exempt flag stops. A stopped channel starts again after a fixed latency plus its own digital delay. Exempt channels keep running without a break. At each qualified request the block checks the half-step rule of the qualifying channel: its half-step bit must be 1 for an odd divide and 0 for an even one. A mismatch raises an error flag.

Top module: `cdv_bank`

## Requirements
- R1: While rst_ni is low, every clk_o bit and hs_err_o are 0. After release all channels start on the same distribution-clock edge, so channels with equal settings are in phase.
- R2: Channel i reads its divide value d from div_i[i*DIV_W +: DIV_W]. For d >= 2 its output has a period of d cycles, is high for floor(d/2) cycles and then low for the rest. For d of 0 or 1 the output follows clk_i while the channel runs.
- R3: When half_i[i] is 1, channel i's output is delayed by half a distribution-clock period. Every edge moves one half period later.
- R4: Each edge, rising or falling, of sync_pin_i after a two-flop synchroniser raises one re-alignment request, and so does each change of sync_inv_i. With no such edge, no channel is disturbed.
- R5: A pending request is taken at the next falling edge of the pre-half-step output of the channel chosen by qual_sel_i. If that channel is not exempt, it stays low from that edge and rises exactly FIX_DLY+1+dly cycles later, where dly is read from dly_i[q*DLY_W +: DLY_W].
- R6: Every non-exempt channel rises first at 2*(FIX_DLY+1+dly) + half half-periods after the qualifying edge. Its dly comes from its dly_i field and half is its half_i bit.
- R7: A channel whose nosync_i bit is 1 is not stopped by a request, and its period stays unbroken through the event.
- R8: hs_err_o changes only when a request is taken. It is then set to 1 if the qualifying channel's half_i bit differs from the oddness of its divide value (values 0 and 1 count as odd), and cleared otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Distribution clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_pin_i | input | 1 | Asynchronous re-alignment request pin |
| sync_inv_i | input | 1 | Polarity-invert control bit, also a request source |
| qual_sel_i | input | SEL_W | Index of the qualifying channel |
| div_i | input | NUM_OUT*DIV_W | Divide value per channel |
| dly_i | input | NUM_OUT*DLY_W | Digital restart delay per channel, in cycles |
| half_i | input | NUM_OUT | Half-step enable per channel |
| nosync_i | input | NUM_OUT | Exempt-from-request flag per channel |
| clk_o | output | NUM_OUT | Output clocks |
| hs_err_o | output | 1 | Half-step rule violation at the last taken request |

## Verification
The stimulus sets mix even and odd divides, pass-through channels, spread digital delays, half-step channels and one or two exempt channels. Different channels are chosen as the qualifying one, so an error in the absolute restart latency is told apart from an error in the per-channel offset. Half-step and full-step channels with the same delay would come out equal if the falling-edge register were skipped, so the half-period offset exposes that fault. Rule-respecting and rule-breaking half-step settings alternate, which separates a stuck error flag from a correct one. Requests are raised by the pin, by the invert bit and by no edge at all.

// File: rtl/cdv_pkg.sv
`timescale 1ns/1ps
package cdv_pkg;
  typedef enum logic {CH_WAIT = 1'b0, CH_RUN = 1'b1} ch_state_e;
  localparam int unsigned CDV_SYNC_STAGES = 2;
endpackage

// File: rtl/cdv_sync_oneshot.sv
`timescale 1ns/1ps
module cdv_sync_oneshot import cdv_pkg::*; #(
  parameter int STAGES = CDV_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic inv_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic pol, pol_q, armed_q;

  assign pol = sync_q[STAGES-1] ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      pol_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], pin_i};
      pol_q   <= pol;
      armed_q <= 1'b1;
    end
  end

  // any edge of the corrected level, once history is valid
  assign pulse_o = armed_q & (pol ^ pol_q);
endmodule

// File: rtl/cdv_qualifier.sv
`timescale 1ns/1ps
module cdv_qualifier #(
  parameter int NUM_OUT = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pulse_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_OUT-1:0] fall_i,
  input  logic [NUM_OUT-1:0] half_i,
  input  logic [NUM_OUT-1:0] odd_i,
  output logic               pend_o,
  output logic               hit_o,
  output logic               hs_err_o
);
  logic pend_q, err_q, sel_ok, qual_fall;

  assign sel_ok    = int'(sel_i) < NUM_OUT;
  assign qual_fall = sel_ok & fall_i[sel_i];
  assign hit_o     = pend_q & qual_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pulse_i | (pend_q & ~hit_o);
      if (hit_o) err_q <= half_i[sel_i] ^ odd_i[sel_i];
    end
  end

  assign pend_o   = pend_q;
  assign hs_err_o = err_q;
endmodule

// File: rtl/cdv_channel.sv
`timescale 1ns/1ps
module cdv_channel import cdv_pkg::*; #(
  parameter int DIV_W   = 4,
  parameter int DLY_W   = 4,
  parameter int FIX_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             half_i,
  input  logic             nosync_i,
  input  logic             hit_i,
  output logic             clk_o,
  output logic             fall_o,
  output logic             run_o,
  output logic             odd_o
);
  localparam int WAIT_W = $clog2(FIX_DLY + (1 << DLY_W)) + 1;

  ch_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q, hi_cnt;
  logic [WAIT_W-1:0] wait_q;
  logic pass, run, lvl, wrap, stop, neg_q;

  assign pass   = div_i < DIV_W'(2);
  assign hi_cnt = div_i >> 1;
  assign run    = state_q == CH_RUN;
  assign lvl    = run & (cnt_q < hi_cnt);
  assign wrap   = pass | (cnt_q >= div_i - 1'b1);
  assign stop   = hit_i & ~nosync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_WAIT;
      cnt_q   <= '0;
      wait_q  <= '0;
    end else if (stop) begin
      state_q <= CH_WAIT;
      cnt_q   <= '0;
      wait_q  <= WAIT_W'(FIX_DLY) + WAIT_W'(dly_i);
    end else if (!run) begin
      if (wait_q == '0) begin
        state_q <= CH_RUN;
        cnt_q   <= '0;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // half-step copy from the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= lvl;
  end

  always_comb begin
    if (pass) clk_o = run & (half_i ? ~clk_i : clk_i);
    else      clk_o = half_i ? neg_q : lvl;
  end

  assign fall_o = run & (pass | (cnt_q == hi_cnt - 1'b1));
  assign run_o  = run;
  assign odd_o  = div_i[0] | (div_i == '0);
endmodule

// File: rtl/cdv_bank.sv
`timescale 1ns/1ps
module cdv_bank #(
  parameter int NUM_OUT = 4,
  parameter int DIV_W   = 4,
  parameter int DLY_W   = 4,
  parameter int FIX_DLY = 2,
  localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_pin_i,
  input  logic                     sync_inv_i,
  input  logic [SEL_W-1:0]         qual_sel_i,
  input  logic [NUM_OUT*DIV_W-1:0] div_i,
  input  logic [NUM_OUT*DLY_W-1:0] dly_i,
  input  logic [NUM_OUT-1:0]       half_i,
  input  logic [NUM_OUT-1:0]       nosync_i,
  output logic [NUM_OUT-1:0]       clk_o,
  output logic                     hs_err_o
);
  logic sync_pulse, sync_pend, sync_hit;
  logic [NUM_OUT-1:0] fall_vec, run_vec, odd_vec;

  cdv_sync_oneshot u_oneshot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (sync_pin_i),
    .inv_i   (sync_inv_i),
    .pulse_o (sync_pulse)
  );

  cdv_qualifier #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (sync_pulse),
    .sel_i    (qual_sel_i),
    .fall_i   (fall_vec),
    .half_i   (half_i),
    .odd_i    (odd_vec),
    .pend_o   (sync_pend),
    .hit_o    (sync_hit),
    .hs_err_o (hs_err_o)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    cdv_channel #(.DIV_W(DIV_W), .DLY_W(DLY_W), .FIX_DLY(FIX_DLY)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .div_i    (div_i[i*DIV_W +: DIV_W]),
      .dly_i    (dly_i[i*DLY_W +: DLY_W]),
      .half_i   (half_i[i]),
      .nosync_i (nosync_i[i]),
      .hit_i    (sync_hit),
      .clk_o    (clk_o[i]),
      .fall_o   (fall_vec[i]),
      .run_o    (run_vec[i]),
      .odd_o    (odd_vec[i])
    );
  end
endmodule

// File: rtl/cdv_bank_chk.sv
`timescale 1ns/1ps
module cdv_bank_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_pulse_i,
  input logic               sync_pend_i,
  input logic               sync_hit_i,
  input logic [NUM_OUT-1:0] run_i,
  input logic [NUM_OUT-1:0] nosync_i,
  input logic               hs_err_i
);
  assert_pend_after_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse_i |=> sync_pend_i);

  assert_pend_consumed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_hit_i && !sync_pulse_i) |=> !sync_pend_i);

  assert_stop_on_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_hit_i |=> ((run_i & ~$past(nosync_i)) == '0));

  assert_exempt_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_hit_i |=> ((run_i & $past(run_i & nosync_i)) == $past(run_i & nosync_i)));

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_hit_i |=> $stable(hs_err_i));
endmodule

bind cdv_bank cdv_bank_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_pulse_i (sync_pulse),
  .sync_pend_i  (sync_pend),
  .sync_hit_i   (sync_hit),
  .run_i        (run_vec),
  .nosync_i     (nosync_i),
  .hs_err_i     (hs_err_o)
);

// File: tb/cdv_bank_tb.sv
`timescale 1ns/1ps
module cdv_bank_tb;
  localparam int N = 4, DW = 4, LW = 4, FIX = 2;

  typedef struct packed {
    logic [15:0] div;
    logic [15:0] dly;
    logic [3:0]  half;
    logic [3:0]  nos;
    logic [1:0]  qsel;
    logic        err;
  } vec_t;

  // channel 0 in the low nibble
  localparam vec_t VECS [7] = '{
    '{16'h2222, 16'h0000, 4'b0000, 4'b0000, 2'd0, 1'b0},
    '{16'h3242, 16'h1530, 4'b0000, 4'b0000, 2'd1, 1'b0},
    '{16'h7423, 16'h0102, 4'b0101, 4'b1000, 2'd0, 1'b0},
    '{16'h5213, 16'h0240, 4'b0000, 4'b1000, 2'd0, 1'b1},
    '{16'h6124, 16'h0307, 4'b0110, 4'b1000, 2'd1, 1'b1},
    '{16'h2232, 16'h00F0, 4'b0000, 4'b0101, 2'd1, 1'b1},
    '{16'h4444, 16'h1111, 4'b1111, 4'b0000, 2'd3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b1, pin = 1'b0, inv = 1'b0;
  logic [1:0]  qsel = '0;
  logic [15:0] div = 16'h2222, dly = '0;
  logic [3:0]  half = '0, nos = '0;
  logic [3:0]  clko;
  logic        herr;

  always #2 clk = ~clk;

  cdv_bank #(.NUM_OUT(N), .DIV_W(DW), .DLY_W(LW), .FIX_DLY(FIX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_pin_i(pin), .sync_inv_i(inv),
    .qual_sel_i(qsel), .div_i(div), .dly_i(dly), .half_i(half),
    .nosync_i(nos), .clk_o(clko), .hs_err_o(herr)
  );

  int total = 0, bad = 0, th = 0;
  bit mon = 0;
  int last_rise [N], last_fall [N], hi_len [N], per [N], restart [N], rs_run [N], per_bad [N];
  logic prev [N];

  initial for (int c = 0; c < N; c++) begin
    last_rise[c] = -1; last_fall[c] = -1; hi_len[c] = 0; per[c] = 0;
    restart[c] = -1; rs_run[c] = 0; per_bad[c] = 0; prev[c] = 1'b0;
  end

  function automatic int eff_div(int c);
    int d = int'(div[c*DW +: DW]);
    return (d < 2) ? 1 : d;
  endfunction

  function automatic int norm_low(int c);
    int d = eff_div(c);
    return (d == 1) ? 1 : 2 * (d - d / 2);
  endfunction

  // sample in half-period units, 1 ns after each clock edge
  always @(clk) begin
    #1;
    th++;
    for (int c = 0; c < N; c++) begin
      if (clko[c] && !prev[c]) begin
        if (mon) begin
          if (restart[c] < 0 && last_fall[c] >= 0 && th - last_fall[c] > norm_low(c)) begin
            restart[c] = th;
            rs_run[c]  = th - last_fall[c];
          end
          if (nos[c] && last_rise[c] >= 0 && th - last_rise[c] != 2 * eff_div(c)) per_bad[c]++;
        end
        if (last_rise[c] >= 0) per[c] = th - last_rise[c];
        last_rise[c] = th;
      end else if (!clko[c] && prev[c]) begin
        hi_len[c]    = th - last_rise[c];
        last_fall[c] = th;
      end
      prev[c] = clko[c];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic apply(input vec_t v);
    tick(1);
    div = v.div; dly = v.dly; half = v.half; nos = v.nos; qsel = v.qsel;
    tick(40);
  endtask

  // mode 0: pin toggle, 1: invert-bit toggle, 2: no request
  task automatic window(input int mode);
    for (int c = 0; c < N; c++) begin restart[c] = -1; per_bad[c] = 0; end
    mon = 1;
    tick(1);
    if (mode == 0) pin = ~pin;
    else if (mode == 1) inv = ~inv;
    tick(80);
    mon = 0;
  endtask

  task automatic check_vec(input vec_t v);
    int q, dq, hq, e0;
    q  = int'(v.qsel);
    dq = int'(v.dly[q*LW +: LW]);
    hq = int'(v.half[q]);
    chk("R5 qualifying channel low run", rs_run[q], 2 * (FIX + 1 + dq));
    e0 = restart[q] - 2 * (FIX + 1 + dq) - hq;
    for (int c = 0; c < N; c++) begin
      if (v.nos[c]) begin
        chk("R7 exempt period breaks", per_bad[c], 0);
        chk("R7 exempt not restarted", restart[c], -1);
      end else if (v.half[c]) begin
        chk("R3 half-step restart phase", restart[c],
            e0 + 2 * (FIX + 1 + int'(v.dly[c*LW +: LW])) + 1);
      end else begin
        chk("R6 restart phase", restart[c], e0 + 2 * (FIX + 1 + int'(v.dly[c*LW +: LW])));
      end
    end
    chk("R8 half-step error flag", int'(herr), int'(v.err));
  endtask

  initial begin : watchdog
    #400000;
    bad++;
    $display("FAIL watchdog req=all act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    #1 rst_n = 1'b0;
    tick(4);
    chk("R1 outputs low in reset", int'(clko), 0);
    chk("R1 error flag low in reset", int'(herr), 0);
    rst_n = 1'b1;
    tick(10);
    for (int c = 1; c < N; c++) chk("R1 aligned start", last_rise[c], last_rise[0]);

    foreach (VECS[i]) begin
      apply(VECS[i]);
      window(0);
      check_vec(VECS[i]);
    end

    // R2 shape per divide value
    apply('{16'h6153, 16'h0000, 4'b0000, 4'b1111, 2'd0, 1'b0});
    chk("R2 div3 high", hi_len[0], 2);  chk("R2 div3 period", per[0], 6);
    chk("R2 div5 high", hi_len[1], 4);  chk("R2 div5 period", per[1], 10);
    chk("R2 pass high", hi_len[2], 1);  chk("R2 pass period", per[2], 2);
    chk("R2 div6 high", hi_len[3], 6);  chk("R2 div6 period", per[3], 12);

    // R4 request sources
    apply(VECS[0]);
    window(1);
    chk("R4 invert-bit toggle restarts", int'(restart[0] >= 0), 1);
    window(0);
    chk("R4 pin edge restarts", int'(restart[0] >= 0), 1);
    window(2);
    chk("R4 no edge no restart", restart[0], -1);
    chk("R4 no edge no restart ch3", restart[3], -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule